// File: doc/BRIEF.md
# Flash Command and Interrupt Status Unit

This unit is the register-facing control point of a NAND-style flash controller. Software writes an opcode into a command register. The unit classifies that opcode and, for load, program and erase work, sends a one-cycle request to a back end that moves the data. When the back end answers with its done pulse, the unit records completion and any failure in two registers:

- an interrupt status word, whose bit 15 is the master flag;
- a controller status word that holds four sticky error bits.

A configuration word chooses the active level of the interrupt pin and drives a ready output. Software clears completion by writing an AND mask into the interrupt status word. Clearing the master bit also wipes the error bits.

Two resets exist. The synchronous chip reset is the cold reset. A warm reset comes either from a dedicated input pulse or from the two reset opcodes. The two differ only in the interrupt status value they leave behind.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After the active-low chip reset, interrupt status reads 0x8080, controller status 0x0000, configuration 0x40C0, command 0x0000, ready is 1 and no request is issued.
- R2: A warm reset (input `warm_rst` high at a clock edge, or an accepted command 0x00F0 or 0x00F3) sets interrupt status to 0x8010 and returns every other register to its R1 value.
- R3: Register offsets are command 0x0, configuration 0x1 (read back ANDed with 0xFFE0), controller status 0x2 and interrupt status 0x3. Any other offset reads 0 and ignores writes.
- R4: A command write is discarded, with the command register unchanged and no request issued, while interrupt status bit 15 is set or a back-end operation is outstanding.
- R5: An accepted load, program or erase opcode raises `op_req` for exactly one cycle, in the cycle after the write, with `op_code` equal to the opcode's low byte.
- R6: On `op_done`, interrupt status gains bit 15 plus bit 7 for load (0x0000, 0x0013), bit 6 for program (0x0080, 0x001A, 0x001B) or bit 5 for erase (0x0094, 0x0095, 0x0030).
- R7: If `op_err` is high with `op_done`, controller status gains bit 10 plus bit 13 (load), bit 12 (program) or bit 11 (erase).
- R8: Command 0x00B0 changes nothing except the command register. Any opcode not listed in R2, R6 or here (all 16 bits compared) sets status bit 10 and interrupt bit 15 and issues no request.
- R9: A write to interrupt status ANDs the written value into it. If bit 15 is then clear, status bits 13..10 are cleared.
- R10: The `irq` output equals interrupt status bit 15 XOR the inverse of configuration bit 6.
- R11: A configuration write sets `rdy` to bit 7 of the written value.
- R12: An `op_done` pulse with no operation outstanding changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| warm_rst | input | 1 | Warm reset request, one cycle |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| op_req | output | 1 | One-cycle operation request to the back end |
| op_code | output | 8 | Opcode carried with the request |
| op_done | input | 1 | One-cycle completion from the back end |
| op_err | input | 1 | Failure flag, valid with `op_done` |
| irq | output | 1 | Interrupt pin, level set by configuration |
| rdy | output | 1 | Ready output |

## Verification
Every register result becomes readable in the cycle after the clock edge that captures the write, the done pulse or the reset. `op_req` is high only during the cycle that follows an accepted command write. `irq` is a function of registers only, so it changes in the same cycle as the register behind it. The bench drives inputs on falling edges and reads the combinational read port or the pins one falling edge after each capturing rising edge. A check therefore always sees a result exactly one edge after its cause, never early and never two edges late.

// File: rtl/fcu_pkg.sv
// Shared constants and types for the flash command unit.
// Assumes 16-bit registers; bit positions are fixed by software.
package fcu_pkg;
    localparam int REG_W = 16;

    // interrupt status bit positions
    localparam int INT_MASTER = 15;
    localparam int INT_LOAD   = 7;
    localparam int INT_PROG   = 6;
    localparam int INT_ERASE  = 5;

    // error field: err[0]=status bit 10 (command), [1]=11 erase, [2]=12 program, [3]=13 load
    localparam int ERR_LSB = 10;
    localparam int ERR_N   = 4;

    localparam logic [REG_W-1:0] INT_COLD    = 16'h8080;
    localparam logic [REG_W-1:0] INT_WARM    = 16'h8010;
    localparam logic [REG_W-1:0] CFG_INIT    = 16'h40C0;
    localparam logic [REG_W-1:0] CFG_RD_MASK = 16'hFFE0;
    localparam int CFG_POL_BIT = 6;
    localparam int CFG_RDY_BIT = 7;

    typedef enum logic [2:0] {
        OPC_NONE, OPC_LOAD, OPC_PROG, OPC_ERASE, OPC_RESET, OPC_BAD
    } op_class_e;
endpackage

// File: rtl/fcu_opdec.sv
// Opcode classifier: maps a full 16-bit command word onto an operation class.
// Purely combinational; every unlisted value is classed as undefined.
module fcu_opdec
    import fcu_pkg::*;
(
    input  logic [REG_W-1:0] cmd,
    output op_class_e        cls
);
    // classify the command word
    always_comb begin
        case (cmd)
            16'h0000, 16'h0013:           cls = OPC_LOAD;
            16'h0080, 16'h001A, 16'h001B: cls = OPC_PROG;
            16'h0094, 16'h0095, 16'h0030: cls = OPC_ERASE;
            16'h00F0, 16'h00F3:           cls = OPC_RESET;
            16'h00B0:                     cls = OPC_NONE;
            default:                      cls = OPC_BAD;
        endcase
    end
endmodule

// File: rtl/fcu_intstat.sv
// Interrupt status word and sticky error bits.
// Assumes a mask write and an event may share a cycle: the mask is applied first, then the event ORs in.
module fcu_intstat
    import fcu_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             warm,
    input  logic             mask_we,
    input  logic [REG_W-1:0] mask,
    input  logic             ev_valid,
    input  logic [REG_W-1:0] ev_int,
    input  logic [ERR_N-1:0] ev_err,
    output logic [REG_W-1:0] ints,
    output logic [REG_W-1:0] status
);
    logic [REG_W-1:0] ints_q, ints_nx;
    logic [ERR_N-1:0] err_q, err_nx;

    // next state: acknowledge mask, then new completion and error flags
    always_comb begin
        ints_nx = ints_q;
        err_nx  = err_q;
        if (mask_we) begin
            ints_nx = ints_q & mask;
            if (!ints_nx[INT_MASTER]) err_nx = '0;
        end
        if (ev_valid) begin
            ints_nx = ints_nx | ev_int;
            err_nx  = err_nx | ev_err;
        end
    end

    // state registers with cold and warm reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ints_q <= INT_COLD;
            err_q  <= '0;
        end else if (warm) begin
            ints_q <= INT_WARM;
            err_q  <= '0;
        end else begin
            ints_q <= ints_nx;
            err_q  <= err_nx;
        end
    end

    assign ints   = ints_q;
    assign status = REG_W'({err_q, ERR_LSB'(0)});

    // R9
    err_needs_master_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|err_q) |-> ints_q[INT_MASTER]);
    // R9
    ack_clears_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_we && !warm && !ev_valid && !mask[INT_MASTER]) |=> (err_q == '0));
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command and interrupt status unit (top).
// Holds command and configuration registers, issues one-cycle back-end requests,
// and folds completions into the interrupt and status words. Assumes the back end
// answers each request with exactly one done pulse.
module flash_cmd_ctrl
    import fcu_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int CODE_W = 8,
    parameter logic [ADDR_W-1:0] OFS_CMD  = 'h0,
    parameter logic [ADDR_W-1:0] OFS_CFG  = 'h1,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'h2,
    parameter logic [ADDR_W-1:0] OFS_INT  = 'h3
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              op_req,
    output logic [CODE_W-1:0] op_code,
    input  logic              op_done,
    input  logic              op_err,
    output logic              irq,
    output logic              rdy
);
    logic [REG_W-1:0]  cmd_q, cfg_q, ints, status;
    logic [CODE_W-1:0] code_q;
    logic              rdy_q, req_q, pend_q;
    op_class_e         pend_cls_q, cls;
    logic              cmd_we, cfg_we, int_we, cmd_take, backend, warm_go, bad, done_ok;
    logic [REG_W-1:0]  ev_int;
    logic [ERR_N-1:0]  ev_err;

    fcu_opdec u_dec (.cmd(reg_wdata), .cls(cls));

    // write decode and command acceptance
    always_comb begin
        cmd_we   = reg_we && (reg_addr == OFS_CMD);
        cfg_we   = reg_we && (reg_addr == OFS_CFG);
        int_we   = reg_we && (reg_addr == OFS_INT);
        cmd_take = cmd_we && !ints[INT_MASTER] && !pend_q;
        backend  = (cls == OPC_LOAD) || (cls == OPC_PROG) || (cls == OPC_ERASE);
        warm_go  = warm_rst || (cmd_take && cls == OPC_RESET);
        bad      = cmd_take && (cls == OPC_BAD);
        done_ok  = op_done && pend_q;
    end

    // completion and error event for the status block
    always_comb begin
        ev_int = '0;
        ev_err = '0;
        if (bad) begin
            ev_int[INT_MASTER] = 1'b1;
            ev_err[0]          = 1'b1;
        end
        if (done_ok) begin
            ev_int[INT_MASTER] = 1'b1;
            case (pend_cls_q)
                OPC_LOAD:  ev_int[INT_LOAD]  = 1'b1;
                OPC_PROG:  ev_int[INT_PROG]  = 1'b1;
                OPC_ERASE: ev_int[INT_ERASE] = 1'b1;
                default:   ;
            endcase
            if (op_err) begin
                ev_err[0] = 1'b1;
                case (pend_cls_q)
                    OPC_LOAD:  ev_err[3] = 1'b1;
                    OPC_PROG:  ev_err[2] = 1'b1;
                    OPC_ERASE: ev_err[1] = 1'b1;
                    default:   ;
                endcase
            end
        end
    end

    // command, configuration, ready and request registers
    always_ff @(posedge clk) begin
        if (!rst_n || warm_go) begin
            cmd_q      <= '0;
            cfg_q      <= CFG_INIT;
            rdy_q      <= 1'b1;
            req_q      <= 1'b0;
            pend_q     <= 1'b0;
            code_q     <= '0;
            pend_cls_q <= OPC_NONE;
        end else begin
            req_q <= 1'b0;
            if (cmd_take) begin
                cmd_q <= reg_wdata;
                if (backend) begin
                    req_q      <= 1'b1;
                    code_q     <= reg_wdata[CODE_W-1:0];
                    pend_q     <= 1'b1;
                    pend_cls_q <= cls;
                end
            end
            if (done_ok) pend_q <= 1'b0;
            if (cfg_we) begin
                cfg_q <= reg_wdata;
                rdy_q <= reg_wdata[CFG_RDY_BIT];
            end
        end
    end

    fcu_intstat u_ints (
        .clk(clk), .rst_n(rst_n), .warm(warm_go),
        .mask_we(int_we), .mask(reg_wdata),
        .ev_valid(bad || done_ok), .ev_int(ev_int), .ev_err(ev_err),
        .ints(ints), .status(status)
    );

    // register read mux
    always_comb begin
        if (reg_addr == OFS_CMD)       reg_rdata = cmd_q;
        else if (reg_addr == OFS_CFG)  reg_rdata = cfg_q & CFG_RD_MASK;
        else if (reg_addr == OFS_STAT) reg_rdata = status;
        else if (reg_addr == OFS_INT)  reg_rdata = ints;
        else                           reg_rdata = '0;
    end

    assign irq     = ints[INT_MASTER] ^ ~cfg_q[CFG_POL_BIT];
    assign rdy     = rdy_q;
    assign op_req  = req_q;
    assign op_code = code_q;

    // R5
    op_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_req |=> !op_req);
    // R4
    cmd_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && (ints[INT_MASTER] || pend_q) && !warm_rst) |=> ($stable(cmd_q) && !op_req));
    // R11
    rdy_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !warm_rst) |=> (rdy == $past(reg_wdata[CFG_RDY_BIT])));
    // R12
    stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && !pend_q && !reg_we && !warm_rst) |=> ($stable(ints) && $stable(status)));
endmodule

// File: tb/sim_flash_cmd_ctrl.sv
module sim_flash_cmd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        warm_rst = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        op_req;
    logic [7:0]  op_code;
    logic        op_done = 1'b0;
    logic        op_err = 1'b0;
    logic        irq, rdy;
    int n_chk = 0;
    int n_fail = 0;

    localparam logic [3:0] A_CMD = 4'h0, A_CFG = 4'h1, A_ST = 4'h2, A_INT = 4'h3;

    always #10 clk = ~clk;

    flash_cmd_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .warm_rst(warm_rst), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_req(op_req), .op_code(op_code), .op_done(op_done), .op_err(op_err),
        .irq(irq), .rdy(rdy)
    );

    // vector: command, back-end error, expected interrupt status, expected status
    localparam int NV = 13;
    localparam logic [48:0] VEC [NV] = '{
        {16'h0000, 1'b0, 16'h8080, 16'h0000},  // R6 load
        {16'h0000, 1'b1, 16'h8080, 16'h2400},  // R7 load error
        {16'h0013, 1'b0, 16'h8080, 16'h0000},  // R6
        {16'h0080, 1'b0, 16'h8040, 16'h0000},  // R6 program
        {16'h001A, 1'b1, 16'h8040, 16'h1400},  // R7 program error
        {16'h001B, 1'b0, 16'h8040, 16'h0000},  // R6
        {16'h0094, 1'b1, 16'h8020, 16'h0C00},  // R7 erase error
        {16'h0095, 1'b0, 16'h8020, 16'h0000},  // R6 erase
        {16'h0030, 1'b0, 16'h8020, 16'h0000},  // R6
        {16'h00B0, 1'b0, 16'h0000, 16'h0000},  // R8 no effect
        {16'h0055, 1'b0, 16'h8000, 16'h0400},  // R8 undefined
        {16'h0113, 1'b0, 16'h8000, 16'h0400},  // R8 upper byte set
        {16'h00F3, 1'b0, 16'h8010, 16'h0000}   // R2 warm by opcode
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic done_pulse(input logic e);
        op_done = 1'b1; op_err = e;
        @(negedge clk);
        op_done = 1'b0; op_err = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 cold reset state
        rd(A_INT, v);  chk("R1 int", v, 16'h8080);
        rd(A_ST, v);   chk("R1 status", v, 16'h0000);
        rd(A_CFG, v);  chk("R1 cfg", v, 16'h40C0);
        rd(A_CMD, v);  chk("R1 cmd", v, 16'h0000);
        chk("R1 rdy/req/irq", {13'd0, rdy, op_req, irq}, 16'h0005);

        // R4 master bit set after reset blocks commands
        wr(A_CMD, 16'h0080);
        chk("R4 no req", {15'd0, op_req}, 16'h0000);
        rd(A_CMD, v);  chk("R4 cmd kept", v, 16'h0000);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [15:0] c, ei, es;
            logic e, be;
            {c, e, ei, es} = VEC[i];
            be = |ei[7:5];
            wr(A_INT, 16'h0000);
            wr(A_CMD, c);
            if (be) begin
                chk("R5 req/code", {7'd0, op_req, op_code}, {8'h01, c[7:0]});
                done_pulse(e);
                chk("R5 one cycle", {15'd0, op_req}, 16'h0000);
            end else begin
                chk("R8 no req", {15'd0, op_req}, 16'h0000);
            end
            rd(A_INT, v); chk("R6/R8 int", v, ei);
            rd(A_ST, v);  chk("R7 status", v, es);
        end

        // R4 outstanding operation blocks a second command
        wr(A_INT, 16'h0000);
        wr(A_CMD, 16'h0080);
        wr(A_CMD, 16'h0094);
        chk("R4 pending no req", {15'd0, op_req}, 16'h0000);
        rd(A_CMD, v); chk("R4 pending cmd", v, 16'h0080);
        done_pulse(1'b1);
        rd(A_INT, v); chk("R6 after pending", v, 16'h8040);

        // R9 partial mask keeps errors while master set, full clear wipes them
        wr(A_INT, 16'hFFBF);
        rd(A_INT, v); chk("R9 and mask", v, 16'h8000);
        rd(A_ST, v);  chk("R9 errors kept", v, 16'h1400);
        wr(A_INT, 16'h7FFF);
        rd(A_ST, v);  chk("R9 errors cleared", v, 16'h0000);

        // R12 stray done ignored
        done_pulse(1'b1);
        rd(A_INT, v); chk("R12 int", v, 16'h0000);
        rd(A_ST, v);  chk("R12 status", v, 16'h0000);

        // R10 / R11 polarity and ready
        chk("R10 irq idle active-high", {15'd0, irq}, 16'h0000);
        wr(A_CFG, 16'h0000);
        chk("R10 irq low-active idle", {15'd0, irq}, 16'h0001);
        chk("R11 rdy low", {15'd0, rdy}, 16'h0000);
        wr(A_CMD, 16'h0077);
        chk("R10 irq low-active asserted", {15'd0, irq}, 16'h0000);
        wr(A_CFG, 16'hFFFF);
        chk("R10 irq high-active asserted", {15'd0, irq}, 16'h0001);
        chk("R11 rdy high", {15'd0, rdy}, 16'h0001);
        rd(A_CFG, v); chk("R3 cfg mask", v, 16'hFFE0);

        // R3 unmapped offset
        wr(4'hF, 16'hFFFF);
        rd(4'hF, v);  chk("R3 unmapped read", v, 16'h0000);
        rd(A_INT, v); chk("R3 unmapped write", v, 16'h8000);

        // R2 warm reset pin
        @(negedge clk); warm_rst = 1'b1;
        @(negedge clk); warm_rst = 1'b0;
        rd(A_INT, v); chk("R2 int", v, 16'h8010);
        rd(A_CFG, v); chk("R2 cfg", v, 16'h40C0);
        rd(A_ST, v);  chk("R2 status", v, 16'h0000);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule